// File: doc/BRIEF.md
# DMA Bus Share Limiter and Priority Idle Timer

This block sits beside a DMA engine and decides two things every clock. First, it tells the engine whether it may ask for the shared bus this cycle, so that the engine's share of bus cycles over any run of eight clocks stays under a programmable cap. The cap is one of four power-of-two fractions. Second, when the active channel is marked as a priority channel and keeps the bus while its I/O card stays silent, it counts those idle cycles. After a programmable number of them it pulses a release signal so that the bus is given back.

Software-facing logic loads a 2-bit share code and a 2-bit idle-limit code through a write strobe. A channel reset returns both codes to their least restrictive and shortest settings. The engine reports each cycle in which it holds the bus. The block uses that history for the share cap and, together with the priority flag and the card's request line, for the idle timer.

Top module: `bus_throttle_wait`

## Requirements
- R1: The share code sets a cap of owned cycles per window of 8 clocks: code 0 gives 8, 1 gives 4, 2 gives 2 and 3 gives 1. `req_permit` is high in a cycle exactly when the number of cycles with `bus_owned` high among the previous 7 cycles is below the cap.
- R2: With share code 0, `req_permit` stays high in every cycle, whatever the ownership history.
- R3: When `cfg_we` is high at a clock edge, `cfg_share` and `cfg_idle` are stored and govern behaviour from the next cycle.
- R4: When `chan_reset` is high at a clock edge, both stored codes become 0, and this overrides `cfg_we` in the same cycle. The idle count is also cleared.
- R5: A cycle is idle when `prio`=1, `bus_owned`=1 and `periph_req`=0. Idle code 0, 1, 2 and 3 gives a limit of 4, 8, 16 and 32 idle cycles. `bus_release` is high during the idle cycle that completes that many consecutive idle cycles.
- R6: `bus_release` lasts one cycle, and the count then restarts from zero. During an unbroken idle run, pulses therefore recur every limit cycles.
- R7: A cycle with `periph_req` high never shows `bus_release`, and it restarts the idle count from zero.
- R8: With `prio` low or `bus_owned` low, `bus_release` stays low and the idle count restarts from zero.
- R9: After `rst_n` is released, both codes are 0, `req_permit` is high and `bus_release` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_reset | input | 1 | Channel reset: restores default codes |
| cfg_we | input | 1 | Write strobe for the two codes |
| cfg_share | input | 2 | Bus share code to store |
| cfg_idle | input | 2 | Idle limit code to store |
| prio | input | 1 | Active channel is a priority channel |
| periph_req | input | 1 | I/O card requests a transfer |
| bus_owned | input | 1 | Engine holds the bus this cycle |
| req_permit | output | 1 | Engine may request or keep the bus |
| bus_release | output | 1 | One-cycle pulse telling the engine to give up the bus |

## Verification
The bench builds the block with its default parameters: an 8-clock window and a base idle limit of 4. At these values all four share caps fit into runs of a few dozen cycles, and so does the longest idle limit of 32. A greedy master model that takes the bus whenever it is permitted produces the steady on/off pattern of each cap. The bench checks that pattern against its own 7-cycle history. Idle runs of twice the limit show the repeated release pulses, and interrupted runs show the count restarting.

// File: rtl/bwt_pkg.sv
package bwt_pkg;

  // owned-cycle cap per window for a share code
  function automatic int unsigned share_cap(input logic [1:0] code, input int unsigned win);
    return win >> code;
  endfunction

  // idle-cycle limit for an idle code
  function automatic int unsigned idle_limit(input logic [1:0] code, input int unsigned base);
    return base << code;
  endfunction

endpackage

// File: rtl/bwt_cfg.sv
module bwt_cfg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chan_reset,
  input  logic       cfg_we,
  input  logic [1:0] cfg_share,
  input  logic [1:0] cfg_idle,
  output logic [1:0] share_code,
  output logic [1:0] idle_code
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      share_code <= 2'd0;
      idle_code  <= 2'd0;
    end else if (chan_reset) begin
      share_code <= 2'd0;
      idle_code  <= 2'd0;
    end else if (cfg_we) begin
      share_code <= cfg_share;
      idle_code  <= cfg_idle;
    end
  end
endmodule

// File: rtl/bwt_window.sv
module bwt_window #(
  parameter int unsigned WIN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_owned,
  input  logic [1:0] share_code,
  output logic       permit,
  output logic [$clog2(WIN+1)-1:0] owned_count
);
  import bwt_pkg::*;
  localparam int unsigned HL = WIN - 1;
  localparam int unsigned CW = $clog2(WIN + 1);

  logic [HL-1:0] hist;
  logic [CW-1:0] cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist <= '0;
    else        hist <= {hist[HL-2:0], bus_owned};
  end

  always_comb begin
    owned_count = '0;
    for (int i = 0; i < int'(HL); i++) owned_count = owned_count + CW'(hist[i]);
  end

  assign cap    = CW'(share_cap(share_code, WIN));
  assign permit = (owned_count < cap);
endmodule

// File: rtl/bwt_idle_timer.sv
module bwt_idle_timer #(
  parameter int unsigned BASE = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chan_reset,
  input  logic       prio,
  input  logic       bus_owned,
  input  logic       periph_req,
  input  logic [1:0] idle_code,
  output logic       idle_cycle,
  output logic       expire
);
  import bwt_pkg::*;
  localparam int unsigned MAXL = BASE << 3;
  localparam int unsigned TW   = $clog2(MAXL);

  logic [TW-1:0] run_cnt;
  logic [TW-1:0] last_idx;

  assign last_idx   = TW'(idle_limit(idle_code, BASE) - 1);
  assign idle_cycle = prio && bus_owned && !periph_req;
  assign expire     = idle_cycle && (run_cnt == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       run_cnt <= '0;
    else if (chan_reset || !idle_cycle || expire) run_cnt <= '0;
    else                              run_cnt <= run_cnt + 1'b1;
  end
endmodule

// File: rtl/bus_throttle_wait.sv
module bus_throttle_wait #(
  parameter int unsigned WIN       = 8,
  parameter int unsigned WAIT_BASE = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chan_reset,
  input  logic       cfg_we,
  input  logic [1:0] cfg_share,
  input  logic [1:0] cfg_idle,
  input  logic       prio,
  input  logic       periph_req,
  input  logic       bus_owned,
  output logic       req_permit,
  output logic       bus_release
);
  localparam int unsigned CW = $clog2(WIN + 1);

  logic [1:0]    share_code;
  logic [1:0]    idle_code;
  logic [CW-1:0] owned_count;
  logic          idle_cycle;

  bwt_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .chan_reset(chan_reset), .cfg_we(cfg_we),
    .cfg_share(cfg_share), .cfg_idle(cfg_idle),
    .share_code(share_code), .idle_code(idle_code)
  );

  bwt_window #(.WIN(WIN)) u_win (
    .clk(clk), .rst_n(rst_n), .bus_owned(bus_owned), .share_code(share_code),
    .permit(req_permit), .owned_count(owned_count)
  );

  bwt_idle_timer #(.BASE(WAIT_BASE)) u_idle (
    .clk(clk), .rst_n(rst_n), .chan_reset(chan_reset), .prio(prio),
    .bus_owned(bus_owned), .periph_req(periph_req), .idle_code(idle_code),
    .idle_cycle(idle_cycle), .expire(bus_release)
  );
endmodule

// File: rtl/bwt_chk.sv
module bwt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       chan_reset,
  input logic       prio,
  input logic       periph_req,
  input logic       bus_owned,
  input logic       req_permit,
  input logic       bus_release,
  input logic [1:0] share_code,
  input logic [1:0] idle_code
);
  // R4
  default_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_reset |=> (share_code == 2'd0 && idle_code == 2'd0));

  // R2
  full_share_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (share_code == 2'd0) |-> req_permit);

  // R1
  eighth_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && share_code == 2'd3 && $past(bus_owned)) |-> !req_permit);

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_release |=> !bus_release);

  // R7
  req_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    periph_req |-> !bus_release);

  // R8
  prio_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!prio || !bus_owned) |-> !bus_release);
endmodule

bind bus_throttle_wait bwt_chk i_bwt_chk (
  .clk(clk), .rst_n(rst_n), .chan_reset(chan_reset), .prio(prio),
  .periph_req(periph_req), .bus_owned(bus_owned), .req_permit(req_permit),
  .bus_release(bus_release), .share_code(share_code), .idle_code(idle_code)
);

// File: tb/test_bus_throttle_wait.sv
module test_bus_throttle_wait;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chan_reset = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_share = 2'd0;
  logic [1:0] cfg_idle = 2'd0;
  logic       prio = 1'b0;
  logic       periph_req = 1'b0;
  logic       bus_owned = 1'b0;
  logic       req_permit;
  logic       bus_release;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bus_throttle_wait i_bus_throttle_wait (
    .clk(clk), .rst_n(rst_n), .chan_reset(chan_reset), .cfg_we(cfg_we),
    .cfg_share(cfg_share), .cfg_idle(cfg_idle), .prio(prio),
    .periph_req(periph_req), .bus_owned(bus_owned),
    .req_permit(req_permit), .bus_release(bus_release)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at falling edge, settle, then caller checks
  task automatic step_drive(input logic own, input logic pr, input logic rq);
    @(negedge clk);
    bus_owned = own; prio = pr; periph_req = rq;
    #1;
  endtask

  task automatic write_cfg(input logic [1:0] sh, input logic [1:0] id);
    @(negedge clk);
    cfg_we = 1'b1; cfg_share = sh; cfg_idle = id;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic flush_history();
    for (int i = 0; i < 8; i++) step_drive(1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_reset_state();
    chk("R9 permit after reset", int'(req_permit), 1);
    chk("R9 release after reset", int'(bus_release), 0);
    // default idle limit of 4 and full share visible at the ports
    step_drive(1'b1, 1'b1, 1'b1);
    for (int k = 1; k <= 4; k++) begin
      step_drive(1'b1, 1'b1, 1'b0);
      chk("R9 default idle limit", int'(bus_release), (k == 4) ? 1 : 0);
    end
    step_drive(1'b0, 1'b0, 1'b0);
  endtask

  // greedy master: takes the bus whenever permitted
  task automatic t_share(input logic [1:0] code, input int cycles);
    logic [6:0] bh;
    int owned_total;
    int cap;
    bit mism;
    cap = 8 >> code;
    write_cfg(code, 2'd0);
    flush_history();
    bh = '0; owned_total = 0; mism = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      #1;
      if ((req_permit == 1'b1) != ($countones(bh) < cap)) mism = 1;
      bus_owned = req_permit;
      if (req_permit) owned_total++;
      bh = {bh[5:0], req_permit};
    end
    chk($sformatf("R1 permit model code %0d", code), int'(mism), 0);
    chk($sformatf("R1 owned total code %0d", code), owned_total, cap * cycles / 8);
    if (code == 2'd0) chk("R2 full share always permitted", owned_total, cycles);
    bus_owned = 1'b0;
  endtask

  task automatic t_idle(input logic [1:0] code);
    int lim;
    int pulses;
    bit bad;
    lim = 4 << code;
    write_cfg(2'd0, code);
    step_drive(1'b1, 1'b1, 1'b1);
    pulses = 0; bad = 0;
    for (int k = 1; k <= 2 * lim + 1; k++) begin
      step_drive(1'b1, 1'b1, 1'b0);
      if (bus_release) pulses++;
      if (bus_release != ((k % lim) == 0)) bad = 1;
    end
    chk($sformatf("R5 release timing code %0d", code), int'(bad), 0);
    chk($sformatf("R6 two pulses code %0d", code), pulses, 2);
    step_drive(1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_restart();
    int seen;
    write_cfg(2'd0, 2'd0);
    step_drive(1'b1, 1'b1, 1'b1);
    seen = 0;
    for (int k = 0; k < 3; k++) begin step_drive(1'b1, 1'b1, 1'b0); seen += int'(bus_release); end
    step_drive(1'b1, 1'b1, 1'b1);
    chk("R7 no release during request", int'(bus_release), 0);
    for (int k = 0; k < 3; k++) begin step_drive(1'b1, 1'b1, 1'b0); seen += int'(bus_release); end
    chk("R7 count restarted by request", seen, 0);
    step_drive(1'b1, 1'b1, 1'b0);
    chk("R7 release after full run", int'(bus_release), 1);
    step_drive(1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_no_prio();
    int seen;
    write_cfg(2'd0, 2'd0);
    seen = 0;
    for (int k = 0; k < 40; k++) begin step_drive(1'b1, 1'b0, 1'b0); seen += int'(bus_release); end
    chk("R8 no release without priority", seen, 0);
    seen = 0;
    for (int k = 0; k < 3; k++) begin step_drive(1'b1, 1'b1, 1'b0); seen += int'(bus_release); end
    step_drive(1'b0, 1'b1, 1'b0);
    seen += int'(bus_release);
    for (int k = 0; k < 3; k++) begin step_drive(1'b1, 1'b1, 1'b0); seen += int'(bus_release); end
    chk("R8 bus not owned restarts count", seen, 0);
    step_drive(1'b1, 1'b1, 1'b0);
    chk("R8 release after restart", int'(bus_release), 1);
    step_drive(1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_chan_reset();
    int owned_total;
    write_cfg(2'd3, 2'd3);
    flush_history();
    // reset beats a simultaneous write
    @(negedge clk);
    chan_reset = 1'b1; cfg_we = 1'b1; cfg_share = 2'd2; cfg_idle = 2'd2;
    @(negedge clk);
    chan_reset = 1'b0; cfg_we = 1'b0;
    owned_total = 0;
    for (int c = 0; c < 16; c++) begin
      @(negedge clk); #1;
      bus_owned = req_permit;
      owned_total += int'(req_permit);
    end
    chk("R4 share back to full", owned_total, 16);
    step_drive(1'b1, 1'b1, 1'b1);
    for (int k = 1; k <= 4; k++) begin
      step_drive(1'b1, 1'b1, 1'b0);
      chk("R4 idle limit back to 4", int'(bus_release), (k == 4) ? 1 : 0);
    end
    step_drive(1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_cfg_next_cycle();
    // write 12.5% share; the very next cycle a single owned cycle blocks permit
    write_cfg(2'd3, 2'd0);
    flush_history();
    step_drive(1'b1, 1'b0, 1'b0);
    chk("R3 permit before owning", int'(req_permit), 1);
    step_drive(1'b0, 1'b0, 1'b0);
    chk("R3 stored cap blocks permit", int'(req_permit), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset_state();
    t_share(2'd0, 32);
    t_share(2'd1, 32);
    t_share(2'd2, 32);
    t_share(2'd3, 32);
    t_idle(2'd0);
    t_idle(2'd1);
    t_idle(2'd2);
    t_idle(2'd3);
    t_restart();
    t_no_prio();
    t_chan_reset();
    t_cfg_next_cycle();
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule